// File: doc/BRIEF.md
# UART Interrupt Status and FIFO-Level Trigger

This block holds the interrupt state of a UART. Single-cycle event pulses from the receive engine and the modem input set sticky raw status bits. These events are overrun, break, parity error, framing error, receive timeout and CTS change. Two further bits are driven by FIFO occupancy: receive fill and transmit drain. Each is compared against a programmable fraction of the FIFO depth and is latched when the occupancy crosses into the triggering region, not on every character.

Software programs a mask register, a level-select register and a write-one-to-clear port through plain write strobes. A register decoder elsewhere in the chip provides these strobes. The block presents the raw status, the masked status and a single combined interrupt line. The FIFOs, the serial engines and the bus decoding sit outside it. Raw status, mask and level registers all update on the rising clock edge that samples their inputs. The masked status and the combined line follow combinationally from those registers.

Top module: `uart_irq_ctrl`

## Requirements
- R1: An event pulse sets its raw bit at the next edge, and the bit stays set until cleared. The bit positions are: overrun 10, break 9, parity 8, framing 7, receive timeout 6, CTS change 1.
- R2: The masked status equals the raw status ANDed bit for bit with the mask register. A mask write takes effect at the next edge.
- R3: A clear write removes, at the next edge, each raw bit whose data bit is 1. Bits written 0 are left unchanged.
- R4: If an event or trigger for a bit arrives in the same cycle as a clear of that bit, the bit ends up set.
- R5: In the level register, bits 5:3 select the receive fraction and bits 2:0 select the transmit fraction. The codes map as follows: 000 is 1/8, 001 is 1/4, 010 is 1/2, 011 is 3/4 and 100 is 7/8 of DEPTH. The reserved codes 101 to 111 behave as 1/2.
- R6: Raw bit 4 (receive) is set at the edge where the receive occupancy is at or above the threshold after having been below it in the previous cycle. Staying above the threshold does not set it again.
- R7: Raw bit 5 (transmit) is set at the edge where the transmit occupancy is at or below the threshold after having been above it in the previous cycle.
- R8: Bits 3, 2 and 0 of the raw and masked status always read 0, whatever is written.
- R9: The combined interrupt output is 1 exactly when any masked status bit is 1.
- R10: After reset the raw status and mask are 0 and both level fields are 010. An empty transmit FIFO at reset does not raise the transmit bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_overrun_i | input | 1 | Overrun event pulse |
| evt_break_i | input | 1 | Break event pulse |
| evt_parity_i | input | 1 | Parity error event pulse |
| evt_framing_i | input | 1 | Framing error event pulse |
| evt_timeout_i | input | 1 | Receive timeout event pulse |
| evt_cts_i | input | 1 | CTS change event pulse |
| rx_count_i | input | CW | Receive FIFO occupancy |
| tx_count_i | input | CW | Transmit FIFO occupancy |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 11 | Mask register write data |
| level_we_i | input | 1 | Level-select write strobe |
| level_wdata_i | input | 6 | Level-select write data |
| clr_we_i | input | 1 | Clear write strobe |
| clr_wdata_i | input | 11 | Clear bit pattern |
| raw_o | output | 11 | Raw interrupt status |
| masked_o | output | 11 | Masked interrupt status |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The hardest case to reach is a crossing of a FIFO threshold that happens in the same cycle as a level-select rewrite or a clear of that bit. Here the trigger must use the old threshold and must win over the clear. Directed sequences walk the receive count to exactly 7/8 depth and hold it above the threshold after a clear. Random stimulus then moves both occupancies in small steps while rewriting the level codes, reserved codes included, and clearing often. This makes crossings that coincide with writes common.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NB     = 11;
  localparam int B_OE   = 10;
  localparam int B_BE   = 9;
  localparam int B_PE   = 8;
  localparam int B_FE   = 7;
  localparam int B_RT   = 6;
  localparam int B_TX   = 5;
  localparam int B_RX   = 4;
  localparam int B_CTS  = 1;
  localparam logic [NB-1:0] IMPL_MASK = 11'b111_1111_0010;

  typedef enum logic [2:0] {
    LVL_EIGHTH  = 3'd0,
    LVL_QUARTER = 3'd1,
    LVL_HALF    = 3'd2,
    LVL_3QTR    = 3'd3,
    LVL_7EIGHTH = 3'd4
  } lvl_e;

  // Fraction in eighths; reserved codes fall back to one half.
  function automatic int unsigned lvl_eighths(logic [2:0] code);
    case (code)
      LVL_EIGHTH:  return 1;
      LVL_QUARTER: return 2;
      LVL_HALF:    return 4;
      LVL_3QTR:    return 6;
      LVL_7EIGHTH: return 7;
      default:     return 4;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_thresh.sv
module uart_irq_thresh
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter bit IS_RX = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic [2:0]    code_i,
  output logic          hit_o
);
  localparam logic COND_RST = !IS_RX;

  logic [CW-1:0] th;
  logic          cond, cond_q;

  always_comb th = CW'((DEPTH * lvl_eighths(code_i)) >> 3);

  generate
    if (IS_RX) begin : g_fill
      always_comb cond = (count_i >= th);
    end else begin : g_drain
      always_comb cond = (count_i <= th);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= COND_RST;
    else         cond_q <= cond;
  end

  // fire only on entry into the trigger region
  assign hit_o = cond & ~cond_q;
endmodule

// File: rtl/uart_irq_raw.sv
module uart_irq_raw
  import uart_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] set_i,
  input  logic [NB-1:0] clr_i,
  output logic [NB-1:0] raw_o
);
  logic [NB-1:0] raw_q;

  // set after clear: a same-cycle event wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= ((raw_q & ~clr_i) | set_i) & IMPL_MASK;
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_overrun_i,
  input  logic          evt_break_i,
  input  logic          evt_parity_i,
  input  logic          evt_framing_i,
  input  logic          evt_timeout_i,
  input  logic          evt_cts_i,
  input  logic [CW-1:0] rx_count_i,
  input  logic [CW-1:0] tx_count_i,
  input  logic          mask_we_i,
  input  logic [10:0]   mask_wdata_i,
  input  logic          level_we_i,
  input  logic [5:0]    level_wdata_i,
  input  logic          clr_we_i,
  input  logic [10:0]   clr_wdata_i,
  output logic [10:0]   raw_o,
  output logic [10:0]   masked_o,
  output logic          irq_o
);
  logic [NB-1:0] mask_q, set_v, clr_v;
  logic [2:0]    rx_lvl_q, tx_lvl_q;
  logic          rx_hit, tx_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      rx_lvl_q <= LVL_HALF;
      tx_lvl_q <= LVL_HALF;
    end else begin
      if (mask_we_i)  mask_q <= mask_wdata_i & IMPL_MASK;
      if (level_we_i) begin
        rx_lvl_q <= level_wdata_i[5:3];
        tx_lvl_q <= level_wdata_i[2:0];
      end
    end
  end

  uart_irq_thresh #(.DEPTH(DEPTH), .CW(CW), .IS_RX(1'b1)) u_rx_th (
    .clk_i, .rst_ni, .count_i(rx_count_i), .code_i(rx_lvl_q), .hit_o(rx_hit)
  );

  uart_irq_thresh #(.DEPTH(DEPTH), .CW(CW), .IS_RX(1'b0)) u_tx_th (
    .clk_i, .rst_ni, .count_i(tx_count_i), .code_i(tx_lvl_q), .hit_o(tx_hit)
  );

  always_comb begin
    set_v        = '0;
    set_v[B_OE]  = evt_overrun_i;
    set_v[B_BE]  = evt_break_i;
    set_v[B_PE]  = evt_parity_i;
    set_v[B_FE]  = evt_framing_i;
    set_v[B_RT]  = evt_timeout_i;
    set_v[B_TX]  = tx_hit;
    set_v[B_RX]  = rx_hit;
    set_v[B_CTS] = evt_cts_i;
    clr_v        = clr_we_i ? clr_wdata_i : '0;
  end

  uart_irq_raw u_raw (
    .clk_i, .rst_ni, .set_i(set_v), .clr_i(clr_v), .raw_o(raw_o)
  );

  assign masked_o = raw_o & mask_q;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
  parameter int CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          evt_overrun_i,
  input logic          evt_break_i,
  input logic          clr_we_i,
  input logic [10:0]   clr_wdata_i,
  input logic [CW-1:0] rx_count_i,
  input logic [10:0]   raw_o,
  input logic [10:0]   masked_o
);
  AST_OE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_overrun_i |=> raw_o[10]); // R1

  AST_OE_NO_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_o[10]) |-> $past(evt_overrun_i)); // R1

  AST_MASKED_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_o & ~raw_o) == 11'd0); // R2

  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_wdata_i[10] && !evt_overrun_i) |=> !raw_o[10]); // R3

  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_wdata_i[9] && evt_break_i) |=> raw_o[9]); // R4

  AST_RX_NEEDS_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_o[4]) |-> ($past(rx_count_i) != '0)); // R6

  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o[3] | raw_o[2] | raw_o[0] | masked_o[3] | masked_o[2] | masked_o[0]) == 1'b0); // R8
endmodule

bind uart_irq_ctrl uart_irq_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_overrun_i(evt_overrun_i),
  .evt_break_i(evt_break_i), .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i),
  .rx_count_i(rx_count_i), .raw_o(raw_o), .masked_o(masked_o)
);

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctrl;
  localparam int CW = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ev_oe, ev_be, ev_pe, ev_fe, ev_rt, ev_cts;
  logic [CW-1:0] rxc, txc;
  logic mwe, lwe, cwe;
  logic [10:0] mwd, cwd;
  logic [5:0] lwd;
  logic [10:0] raw_o, masked_o;
  logic irq_o;

  int checks = 0, errors = 0;
  logic [10:0] m_raw, m_mask;
  logic [2:0] m_rxl, m_txl;
  logic m_prx, m_ptx;

  always #10 clk = ~clk;

  uart_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .evt_overrun_i(ev_oe), .evt_break_i(ev_be),
    .evt_parity_i(ev_pe), .evt_framing_i(ev_fe), .evt_timeout_i(ev_rt),
    .evt_cts_i(ev_cts), .rx_count_i(rxc), .tx_count_i(txc),
    .mask_we_i(mwe), .mask_wdata_i(mwd), .level_we_i(lwe), .level_wdata_i(lwd),
    .clr_we_i(cwe), .clr_wdata_i(cwd), .raw_o(raw_o), .masked_o(masked_o), .irq_o(irq_o)
  );

  function automatic int thr16(logic [2:0] c);
    case (c)
      3'd0: return 2;
      3'd1: return 4;
      3'd3: return 12;
      3'd4: return 14;
      default: return 8;
    endcase
  endfunction

  task automatic idle();
    {ev_oe, ev_be, ev_pe, ev_fe, ev_rt, ev_cts} = '0;
    {mwe, lwe, cwe} = '0;
    mwd = '0; cwd = '0; lwd = '0;
  endtask

  task automatic check(string tag, logic [10:0] act, logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic rx_c, tx_c;
    logic [10:0] set, clr;
    rx_c = int'(rxc) >= thr16(m_rxl);
    tx_c = int'(txc) <= thr16(m_txl);
    set = '0;
    set[10] = ev_oe; set[9] = ev_be; set[8] = ev_pe; set[7] = ev_fe;
    set[6] = ev_rt; set[5] = tx_c & ~m_ptx; set[4] = rx_c & ~m_prx; set[1] = ev_cts;
    clr = cwe ? cwd : 11'd0;
    @(posedge clk); #1;
    m_raw = ((m_raw & ~clr) | set) & 11'h7F2;
    if (mwe) m_mask = mwd & 11'h7F2;
    if (lwe) begin m_rxl = lwd[5:3]; m_txl = lwd[2:0]; end
    m_prx = rx_c; m_ptx = tx_c;
    check(tag, raw_o, m_raw);
    check("R2", masked_o, m_raw & m_mask);
    check("R9", {10'd0, irq_o}, {10'd0, |(m_raw & m_mask)});
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle(); rxc = '0; txc = '0;
    m_raw = '0; m_mask = '0; m_rxl = 3'd2; m_txl = 3'd2; m_prx = 1'b0; m_ptx = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    check("R10", raw_o, 11'd0);
    check("R10", masked_o, 11'd0);
    check("R10", {10'd0, irq_o}, 11'd0);
    step("R10"); // empty tx at reset must not trigger
    // R1 overrun and CTS events
    ev_oe = 1'b1; step("R1");
    ev_cts = 1'b1; ev_fe = 1'b1; step("R1");
    step("R1"); // sticky
    // R4 event wins over clear; R3 plain clear of overrun
    cwe = 1'b1; cwd = 11'h600; ev_be = 1'b1; step("R4");
    cwe = 1'b1; cwd = 11'h082; step("R3");
    // R8 unsupported bits stay zero
    mwe = 1'b1; mwd = 11'h7FF; step("R8");
    ev_pe = 1'b1; ev_rt = 1'b1; step("R8");
    // R10 default half threshold on rx
    rxc = 5'd7; step("R10");
    rxc = 5'd8; step("R10");
    cwe = 1'b1; cwd = 11'h7FF; step("R3");
    // R5/R6 seven-eighths on rx, 1/8 on tx
    rxc = 5'd0; lwe = 1'b1; lwd = 6'b100_000; step("R5");
    txc = 5'd5; step("R7");
    rxc = 5'd13; step("R5");
    rxc = 5'd14; step("R6");
    cwe = 1'b1; cwd = 11'h010; rxc = 5'd16; step("R6");
    step("R6");
    txc = 5'd2; step("R7");
    // R5 reserved code behaves as one half
    rxc = 5'd0; lwe = 1'b1; lwd = 6'b111_101; step("R5");
    rxc = 5'd8; step("R5");
    // random
    for (int i = 0; i < 3000; i++) begin
      int d;
      ev_oe  = ($urandom_range(9) == 0);
      ev_be  = ($urandom_range(11) == 0);
      ev_pe  = ($urandom_range(13) == 0);
      ev_fe  = ($urandom_range(9) == 0);
      ev_rt  = ($urandom_range(17) == 0);
      ev_cts = ($urandom_range(15) == 0);
      cwe = ($urandom_range(3) == 0); cwd = 11'($urandom);
      mwe = ($urandom_range(19) == 0); mwd = 11'($urandom);
      lwe = ($urandom_range(29) == 0); lwd = 6'($urandom);
      d = int'(rxc) + $urandom_range(6) - 3;
      rxc = CW'(d < 0 ? 0 : (d > 16 ? 16 : d));
      d = int'(txc) + $urandom_range(6) - 3;
      txc = CW'(d < 0 ? 0 : (d > 16 ? 16 : d));
      step("R3");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule